// File: doc/BRIEF.md
# Accumulator ALU with Flag Logic

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each operation takes the accumulator, the B register, a source operand, the incoming carry, auxiliary-carry and overflow flags, and a 5-bit operation code. It returns a new accumulator byte, a new B byte, and next values for the carry (CY), auxiliary carry (AC) and overflow (OV) flags. A parity output follows the returned accumulator at all times. Register files and operand fetch sit outside the block.

An operation starts with a one-cycle `start` strobe. Single-cycle operations finish on the next clock edge. Multiply and divide run a shift-and-add or shift-and-subtract loop, one bit per cycle, and hold `busy` high while it runs. Every finished operation raises `done` for one cycle. The result registers change only at that edge and then hold their value until the next operation finishes.

Top module: `accalu_top`

## Requirements
- R1: After reset, resA, resB, cyOut, acOut, ovOut, parOut, busy and done are all 0.
- R2: Operation codes are ADD=0, ADDC=1, SUBB=2, OR=3, AND=4, XOR=5, INC=6, DEC=7, RR=8, RRC=9, RL=10, RLC=11, SWAP=12, CLR=13, CPL=14, DA=15, MUL=16, DIV=17. Codes 18 to 31 return the accumulator and all flags unchanged. A start taken while idle on any code other than MUL or DIV raises done after the next clock edge. Every operation except MUL and DIV returns bIn as resB. The result outputs change only in a cycle where done is high.
- R3: ADD computes accIn+srcIn and ADDC computes accIn+srcIn+cyIn. CY is the carry out of bit 7. AC is the carry out of bit 3 into bit 4. OV is set when both operands have the same sign and the result sign differs.
- R4: SUBB computes accIn-srcIn-cyIn modulo 256. CY is the borrow out of bit 7. AC is the borrow into bit 4. OV is set when the operand signs differ and the result sign differs from accIn.
- R5: OR, AND and XOR combine accIn with srcIn bit by bit and return cyIn, acIn and ovIn unchanged.
- R6: INC and DEC add or subtract 1 modulo 256 and leave all three flags unchanged. SWAP exchanges the nibbles. CLR returns 0. CPL inverts every bit.
- R7: RR and RL rotate the byte by one place and leave CY unchanged. RRC and RLC rotate through CY as a ninth bit: RRC moves cyIn into bit 7 and bit 0 into CY, and RLC moves cyIn into bit 0 and bit 7 into CY.
- R8: DA adds 0x06 when the low nibble exceeds 9 or acIn is 1. It then adds 0x60 to that sum when the sum's high nibble exceeds 9, when cyIn is 1, or when the first addition carried out of bit 7. CY becomes cyIn OR either carry out of bit 7, so DA never clears CY. AC and OV are unchanged.
- R9: MUL returns the low byte of accIn*bIn in resA and the high byte in resB. It clears CY, sets OV exactly when the high byte is nonzero, and leaves AC unchanged.
- R10: DIV with a nonzero divisor returns accIn/bIn in resA and the remainder in resB, clears CY and OV, and leaves AC unchanged. With bIn=0 it clears CY and sets OV.
- R11: MUL and DIV take the operands present at the start cycle. busy is high from the edge after start until done rises, and done rises 10 clock edges after the start edge (datapath width plus 2). busy and done are never high together.
- R12: parOut is 1 exactly when resA holds an odd number of 1 bits.
- R13: A start seen while busy is high is ignored. The running operation completes with its own operands and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 5 | Operation code |
| accIn | input | 8 | Accumulator operand |
| bIn | input | 8 | B register operand |
| srcIn | input | 8 | Source operand |
| cyIn | input | 1 | Current carry flag |
| acIn | input | 1 | Current auxiliary-carry flag |
| ovIn | input | 1 | Current overflow flag |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle completion pulse |
| resA | output | 8 | Result accumulator |
| resB | output | 8 | Result B register |
| cyOut | output | 1 | Next carry flag |
| acOut | output | 1 | Next auxiliary-carry flag |
| ovOut | output | 1 | Next overflow flag |
| parOut | output | 1 | Parity of resA |

## Verification
The bound checker watches every cycle for the properties that need no arithmetic reference. It checks that the results hold between completions, that busy and done exclude each other, and that a multiply or divide start raises busy. It also checks the flag rules of multiply and divide, including OV on a zero divisor, that the logic operations keep all three flags, and that the plain rotates keep the carry. The exact sums, borrows, nibble carries, decimal-adjust outcomes, products and quotients come only from the bench. The bench sweeps every accumulator value against a spread of operands and carry states. It also fires a second start in the middle of a running multiply to show that the second start is ignored.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_OR   = 5'd3,
    OP_AND  = 5'd4,
    OP_XOR  = 5'd5,
    OP_INC  = 5'd6,
    OP_DEC  = 5'd7,
    OP_RR   = 5'd8,
    OP_RRC  = 5'd9,
    OP_RL   = 5'd10,
    OP_RLC  = 5'd11,
    OP_SWAP = 5'd12,
    OP_CLR  = 5'd13,
    OP_CPL  = 5'd14,
    OP_DA   = 5'd15,
    OP_MUL  = 5'd16,
    OP_DIV  = 5'd17
  } aluOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // capture operands for the iterative unit
    logic wrSimple;  // write a single-cycle result
    logic step;      // one multiply/divide iteration
    logic finish;    // write the multiply/divide result
    logic isDiv;     // iterative unit divides (else multiplies)
  } aluStrobe_t;

endpackage

// File: rtl/accalu_ctrl.sv
module accalu_ctrl
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  aluOp_e     op,
  output logic       busy,
  output logic       done,
  output aluStrobe_t strb
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_ITER, S_FIN} state_e;

  state_e          state;
  logic [CW-1:0]   stepCnt;
  logic            divQ;
  logic            doneQ;
  logic            accept;
  logic            isIter;

  assign isIter = (op == OP_MUL) || (op == OP_DIV);
  assign accept = start && (state == S_IDLE);

  always_comb begin
    strb.load     = accept;
    strb.wrSimple = accept && !isIter;
    strb.step     = (state == S_ITER);
    strb.finish   = (state == S_FIN);
    strb.isDiv    = divQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      divQ    <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= (accept && !isIter) || (state == S_FIN);
      case (state)
        S_IDLE: if (accept && isIter) begin
          state   <= S_ITER;
          stepCnt <= '0;
          divQ    <= (op == OP_DIV);
        end
        S_ITER: begin
          stepCnt <= stepCnt + CW'(1);
          if (stepCnt == CW'(W - 1)) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/accalu_dp.sv
module accalu_dp
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluStrobe_t   strb,
  input  aluOp_e       op,
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] srcIn,
  input  logic         cyIn,
  input  logic         acIn,
  input  logic         ovIn,
  output logic [W-1:0] resA,
  output logic [W-1:0] resB,
  output logic         cyOut,
  output logic         acOut,
  output logic         ovOut,
  output logic         parOut
);
  localparam int H = W / 2;

  // single-cycle result
  logic [W-1:0] sA;
  logic         sCy, sAc, sOv;
  logic [W:0]   wide, daOne, daTwo;
  logic [H:0]   nib;
  logic         cin;

  always_comb begin
    sA    = accIn;
    sCy   = cyIn;
    sAc   = acIn;
    sOv   = ovIn;
    wide  = '0;
    nib   = '0;
    daOne = '0;
    daTwo = '0;
    cin   = (op == OP_ADDC) ? cyIn : 1'b0;
    case (op)
      OP_ADD, OP_ADDC: begin
        wide = {1'b0, accIn} + {1'b0, srcIn} + (W+1)'(cin);
        nib  = {1'b0, accIn[H-1:0]} + {1'b0, srcIn[H-1:0]} + (H+1)'(cin);
        sA   = wide[W-1:0];
        sCy  = wide[W];
        sAc  = nib[H];
        sOv  = (accIn[W-1] == srcIn[W-1]) && (wide[W-1] != accIn[W-1]);
      end
      OP_SUBB: begin
        wide = {1'b0, accIn} - {1'b0, srcIn} - (W+1)'(cyIn);
        nib  = {1'b0, accIn[H-1:0]} - {1'b0, srcIn[H-1:0]} - (H+1)'(cyIn);
        sA   = wide[W-1:0];
        sCy  = wide[W];
        sAc  = nib[H];
        sOv  = (accIn[W-1] != srcIn[W-1]) && (wide[W-1] != accIn[W-1]);
      end
      OP_OR:   sA = accIn | srcIn;
      OP_AND:  sA = accIn & srcIn;
      OP_XOR:  sA = accIn ^ srcIn;
      OP_INC:  sA = accIn + W'(1);
      OP_DEC:  sA = accIn - W'(1);
      OP_RR:   sA = {accIn[0], accIn[W-1:1]};
      OP_RRC: begin
        sA  = {cyIn, accIn[W-1:1]};
        sCy = accIn[0];
      end
      OP_RL:   sA = {accIn[W-2:0], accIn[W-1]};
      OP_RLC: begin
        sA  = {accIn[W-2:0], cyIn};
        sCy = accIn[W-1];
      end
      OP_SWAP: sA = {accIn[H-1:0], accIn[W-1:H]};
      OP_CLR:  sA = '0;
      OP_CPL:  sA = ~accIn;
      OP_DA: begin
        daOne = ((accIn[H-1:0] > H'(9)) || acIn) ? ({1'b0, accIn} + (W+1)'(6))
                                                 : {1'b0, accIn};
        daTwo = ((daOne[W-1:H] > H'(9)) || cyIn || daOne[W])
                  ? ({1'b0, daOne[W-1:0]} + ((W+1)'(6) << H))
                  : {1'b0, daOne[W-1:0]};
        sA  = daTwo[W-1:0];
        sCy = cyIn | daOne[W] | daTwo[W];
      end
      default: ;
    endcase
  end

  // iterative multiply / divide
  logic [W-1:0] hiR, loR, opnd;
  logic         acQ;
  logic [W:0]   mSum, dTmp, dDiff;
  logic         dGe;

  always_comb begin
    mSum  = {1'b0, hiR} + (loR[0] ? {1'b0, opnd} : '0);
    dTmp  = {hiR, loR[W-1]};
    dGe   = (dTmp >= {1'b0, opnd});
    dDiff = dTmp - {1'b0, opnd};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiR  <= '0;
      loR  <= '0;
      opnd <= '0;
      acQ  <= 1'b0;
    end else if (strb.load) begin
      hiR  <= '0;
      loR  <= accIn;
      opnd <= bIn;
      acQ  <= acIn;
    end else if (strb.step) begin
      if (strb.isDiv) begin
        hiR <= dGe ? dDiff[W-1:0] : dTmp[W-1:0];
        loR <= {loR[W-2:0], dGe};
      end else begin
        hiR <= mSum[W:1];
        loR <= {mSum[0], loR[W-1:1]};
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resA  <= '0;
      resB  <= '0;
      cyOut <= 1'b0;
      acOut <= 1'b0;
      ovOut <= 1'b0;
    end else if (strb.wrSimple) begin
      resA  <= sA;
      resB  <= bIn;
      cyOut <= sCy;
      acOut <= sAc;
      ovOut <= sOv;
    end else if (strb.finish) begin
      resA  <= loR;
      resB  <= hiR;
      cyOut <= 1'b0;
      acOut <= acQ;
      ovOut <= strb.isDiv ? (opnd == '0) : (|hiR);
    end
  end

  assign parOut = ^resA;
endmodule

// File: rtl/accalu_top.sv
module accalu_top
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [4:0]   op,
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] srcIn,
  input  logic         cyIn,
  input  logic         acIn,
  input  logic         ovIn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] resA,
  output logic [W-1:0] resB,
  output logic         cyOut,
  output logic         acOut,
  output logic         ovOut,
  output logic         parOut
);
  aluStrobe_t strb;
  aluOp_e     opSel;

  assign opSel = aluOp_e'(op);

  accalu_ctrl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .op(opSel),
    .busy(busy), .done(done), .strb(strb)
  );

  accalu_dp #(.W(W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .op(opSel),
    .accIn(accIn), .bIn(bIn), .srcIn(srcIn),
    .cyIn(cyIn), .acIn(acIn), .ovIn(ovIn),
    .resA(resA), .resB(resB), .cyOut(cyOut), .acOut(acOut),
    .ovOut(ovOut), .parOut(parOut)
  );
endmodule

// File: rtl/accalu_chk.sv
module accalu_chk
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [4:0]   op,
  input logic [W-1:0] bIn,
  input logic         cyIn,
  input logic         acIn,
  input logic         ovIn,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] resA,
  input logic [W-1:0] resB,
  input logic         cyOut,
  input logic         acOut,
  input logic         ovOut
);
  aluOp_e       lastOp;
  logic [W-1:0] lastB;
  logic         lastCy, lastAc, lastOv;
  logic         isLogic, isPlainRot, isIterStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOp <= OP_CLR;
      lastB  <= '0;
      lastCy <= 1'b0;
      lastAc <= 1'b0;
      lastOv <= 1'b0;
    end else if (start && !busy) begin
      lastOp <= aluOp_e'(op);
      lastB  <= bIn;
      lastCy <= cyIn;
      lastAc <= acIn;
      lastOv <= ovIn;
    end
  end

  assign isLogic     = (lastOp == OP_OR) || (lastOp == OP_AND) || (lastOp == OP_XOR);
  assign isPlainRot  = (lastOp == OP_RR) || (lastOp == OP_RL);
  assign isIterStart = start && !busy && ((aluOp_e'(op) == OP_MUL) || (aluOp_e'(op) == OP_DIV));

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(resA) && $stable(resB))); // R2
  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (done && isLogic) |-> (cyOut == lastCy && acOut == lastAc && ovOut == lastOv)); // R5
  AST_ROT_KEEPS_CY: assert property (@(posedge clk) disable iff (!rstN)
    (done && isPlainRot) |-> (cyOut == lastCy)); // R7
  AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (done && lastOp == OP_MUL) |-> (!cyOut && ovOut == (resB != '0) && acOut == lastAc)); // R9
  AST_DIV_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (done && lastOp == OP_DIV) |-> (!cyOut && ovOut == (lastB == '0))); // R10
  AST_ITER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    isIterStart |=> busy); // R11
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done); // R11
endmodule

bind accalu_top accalu_chk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .op(op), .bIn(bIn),
  .cyIn(cyIn), .acIn(acIn), .ovIn(ovIn), .busy(busy), .done(done),
  .resA(resA), .resB(resB), .cyOut(cyOut), .acOut(acOut), .ovOut(ovOut)
);

// File: tb/sim_accalu_top.sv
module sim_accalu_top;
  localparam int CLK_NS = 10;
  localparam int W = 8;
  localparam int ITER_LAT = W + 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] accIn = '0, bIn = '0, srcIn = '0;
  logic       cyIn = 1'b0, acIn = 1'b0, ovIn = 1'b0;
  logic       busy, done, cyOut, acOut, ovOut, parOut;
  logic [7:0] resA, resB;

  int checks = 0;
  int fails = 0;

  always #(CLK_NS / 2) clk = ~clk;

  accalu_top #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .accIn(accIn), .bIn(bIn), .srcIn(srcIn),
    .cyIn(cyIn), .acIn(acIn), .ovIn(ovIn),
    .busy(busy), .done(done), .resA(resA), .resB(resB),
    .cyOut(cyOut), .acOut(acOut), .ovOut(ovOut), .parOut(parOut)
  );

  function automatic string tagOf(int o);
    case (o)
      0, 1:           return "R3";
      2:              return "R4";
      3, 4, 5:        return "R5";
      6, 7, 12, 13, 14: return "R6";
      8, 9, 10, 11:   return "R7";
      15:             return "R8";
      16:             return "R9";
      17:             return "R10";
      default:        return "R2";
    endcase
  endfunction

  // expected {resA, resB, CY, AC, OV}
  function automatic logic [18:0] model(int o, logic [7:0] a, logic [7:0] b,
                                        logic [7:0] s, logic cy, logic ac, logic ov);
    int ia, ib, is, r, t;
    logic [7:0] ra, rb;
    logic c, x, v, ci;
    ia = int'(a); ib = int'(b); is = int'(s);
    ra = a; rb = b; c = cy; x = ac; v = ov;
    ci = (o == 1) ? cy : 1'b0;
    case (o)
      0, 1: begin
        r  = ia + is + int'(ci);
        ra = 8'(r);
        c  = (r > 255);
        x  = ((ia % 16) + (is % 16) + int'(ci)) > 15;
        v  = (a[7] == s[7]) && (ra[7] != a[7]);
      end
      2: begin
        r  = ia - is - int'(cy);
        ra = 8'(r);
        c  = (r < 0);
        x  = ((ia % 16) - (is % 16) - int'(cy)) < 0;
        v  = (a[7] != s[7]) && (ra[7] != a[7]);
      end
      3:  ra = a | s;
      4:  ra = a & s;
      5:  ra = a ^ s;
      6:  ra = 8'(ia + 1);
      7:  ra = 8'(ia + 255);
      8:  ra = 8'((ia / 2) + (ia % 2) * 128);
      9:  begin ra = 8'((ia / 2) + int'(cy) * 128); c = a[0]; end
      10: ra = 8'((ia * 2) % 256 + ia / 128);
      11: begin ra = 8'((ia * 2) % 256 + int'(cy)); c = a[7]; end
      12: ra = 8'((ia % 16) * 16 + ia / 16);
      13: ra = 8'h00;
      14: ra = 8'(255 - ia);
      15: begin
        t = ia;
        if ((ia % 16) > 9 || ac) t = ia + 6;
        r = t % 256;
        if ((r / 16) > 9 || cy || t > 255) r = r + 96;
        ra = 8'(r);
        c  = cy || (t > 255) || (r > 255);
      end
      16: begin
        r  = ia * ib;
        ra = 8'(r % 256);
        rb = 8'(r / 256);
        c  = 1'b0;
        v  = (rb != 8'h00);
      end
      17: begin
        ra = 8'(ia / ib);
        rb = 8'(ia % ib);
        c  = 1'b0;
        v  = 1'b0;
      end
      default: ;
    endcase
    return {ra, rb, c, x, v};
  endfunction

  task automatic fire(int o, logic [7:0] a, logic [7:0] b, logic [7:0] s,
                      logic cy, logic ac, logic ov, output int lat);
    op = 5'(o); accIn = a; bIn = b; srcIn = s;
    cyIn = cy; acIn = ac; ovIn = ov; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runOp(int o, logic [7:0] a, logic [7:0] b, logic [7:0] s,
                       logic cy, logic ac, logic ov);
    int lat, expLat;
    logic [18:0] exp, got;
    fire(o, a, b, s, cy, ac, ov, lat);
    exp    = model(o, a, b, s, cy, ac, ov);
    got    = {resA, resB, cyOut, acOut, ovOut};
    expLat = (o == 16 || o == 17) ? ITER_LAT : 1;
    checks++;
    if (got !== exp || lat != expLat || parOut !== ^exp[18:11]) begin
      fails++;
      $display("FAIL %s (R12 parity, R11 latency) op=%0d a=%h b=%h s=%h cy=%b ac=%b: got A=%h B=%h c/x/v=%b%b%b par=%b lat=%0d, expected A=%h B=%h c/x/v=%b par=%b lat=%0d",
               tagOf(o), o, a, b, s, cy, ac, resA, resB, cyOut, acOut, ovOut, parOut, lat,
               exp[18:11], exp[10:3], exp[2:0], ^exp[18:11], expLat);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got hung run, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (resA !== 8'h00 || resB !== 8'h00 || cyOut || acOut || ovOut || parOut || busy || done) begin
      fails++;
      $display("FAIL R1 got A=%h B=%h c/x/v=%b%b%b par=%b busy=%b done=%b, expected all zero",
               resA, resB, cyOut, acOut, ovOut, parOut, busy, done);
    end

    // R3 R4: add, add with carry, subtract with borrow
    for (int o = 0; o < 3; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          for (int c = 0; c < 2; c++)
            runOp(o, 8'(a), 8'h3C, 8'(k * 17), c[0], ~c[0], c[0]);

    // R5: logic ops with differing flag patterns
    for (int o = 3; o < 6; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          runOp(o, 8'(a), 8'h5A, 8'(k * 17 + 3), k[0], k[1], k[2]);

    // R6 R7: unary ops, R8: decimal adjust
    for (int o = 6; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 4; c++)
          runOp(o, 8'(a), 8'hA5, 8'h00, c[0], c[1], c[0] ^ c[1]);

    // R2: unused codes leave everything unchanged
    for (int o = 18; o < 32; o++)
      for (int k = 0; k < 8; k++)
        runOp(o, 8'(k * 37 + 5), 8'(k * 11), 8'h77, k[0], k[1], k[2]);

    // R9 R10: multiply and nonzero divide
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 8; k++) begin
        runOp(16, 8'(a), 8'(k * 37 + 1), 8'h00, k[0], k[1], k[2]);
        runOp(17, 8'(a), 8'(k * 37 + 1), 8'h00, k[0], k[1], k[2]);
      end
    runOp(16, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);
    runOp(16, 8'h0F, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);

    // R10: divide by zero sets OV, clears CY
    for (int a = 0; a < 256; a += 17) begin
      fire(17, 8'(a), 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, lat);
      checks++;
      if (cyOut !== 1'b0 || ovOut !== 1'b1 || lat != ITER_LAT) begin
        fails++;
        $display("FAIL R10 div by zero a=%h: got cy=%b ov=%b lat=%0d, expected cy=0 ov=1 lat=%0d",
                 a[7:0], cyOut, ovOut, lat, ITER_LAT);
      end
    end

    // R13: start during a running multiply is ignored
    op = 5'd16; accIn = 8'h0F; bIn = 8'h11; srcIn = 8'h00;
    cyIn = 1'b1; acIn = 1'b0; ovIn = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    @(negedge clk); lat++;
    op = 5'd0; accIn = 8'h01; bIn = 8'h02; srcIn = 8'h01; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    checks++;
    if (resA !== 8'hFF || resB !== 8'h00 || cyOut || ovOut || lat != ITER_LAT) begin
      fails++;
      $display("FAIL R13 got A=%h B=%h cy=%b ov=%b lat=%0d, expected A=ff B=00 cy=0 ov=0 lat=%0d",
               resA, resB, cyOut, ovOut, lat, ITER_LAT);
    end
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || busy !== 1'b0 || resA !== 8'hFF) begin
      fails++;
      $display("FAIL R13 after completion got done=%b busy=%b A=%h, expected done=0 busy=0 A=ff",
               done, busy, resA);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule